// File: doc/BRIEF.md
# Multi-Timer Event Capture and Reload Unit

This block holds a small bank of down-counting timers (one to seven) fed by one shared prescaler. Each enabled counter steps down by one per prescaler tick. When an enabled counter is at zero and a tick arrives, it takes its reload value again and pulses its own interrupt line for one cycle. The prescaler is driven either by the system clock or by the synchronized rising edges of a slow external clock pin. A debug-halt input can freeze the prescaler and all counters, unless software has set the bit that forbids freezing.

Software can arm two one-shot actions: a capture, which copies every timer's count into that timer's latch register, and a reload, which loads every timer from its reload register. Both fire on the next rising edge of any event source picked by a 32-bit select mask. The sources are either the lower 32 lines of a 64-bit interrupt bus, or lines 61:32 of that bus together with an external time-tick strobe and an external sync strobe. A small state machine holds what is armed. Its states are ARM_NONE, ARM_CAPT, ARM_LOAD and ARM_BOTH, encoded as {reload, capture}. A configuration write moves it to the state given by config bits 12 and 11. A selected event in any armed state moves it to ARM_NONE. When a write and an event fall in the same cycle, the write decides the next state. In ARM_NONE, events are ignored.

Word addresses: 0 is the config register, 1 is the event mask, 2 is the prescaler reload, and 3 is the prescaler count. Timer n occupies addresses 4(n+1) to 4(n+1)+3, holding in turn its count, reload, control (bit 0 is the enable) and latch (read only). The halt input freezes counting only. Register writes and events still act while it is asserted.

Top module: `mtimer_latch_unit`

## Requirements
- R1: The config register reads bit 13 as the event-bank select, bits 12 and 11 as the armed reload and capture, bit 10 as the external prescaler clock select, bit 9 as the no-freeze bit, bit 8 as constant 1 and bits 2:0 as the timer count. All other bits read 0.
- R2: Writing 1 to config bit 16+n sets timer n's enable (control bit 0). Writing 0 there leaves the enable unchanged.
- R3: A prescaler count of zero on an input pulse reloads the prescaler count and gives one tick, so ticks come every reload+1 pulses. An enabled counter decrements by one per tick, and a disabled counter holds.
- R4: An enabled counter at zero takes its reload value on the next tick. Its interrupt output is high for exactly the one cycle after that clock edge.
- R5: With config bit 9 at 0, a high halt input stops the prescaler and all counters. With bit 9 at 1, halt has no effect.
- R6: With config bit 10 set, each synchronized rising edge of the external clock is one prescaler pulse, and system clock cycles alone cause no count.
- R7: With config bit 11 set, the next selected event copies every count into that timer's latch, and bit 11 then reads 0.
- R8: With config bit 12 set, the next selected event loads every counter from its reload register, and bit 12 then reads 0.
- R9: With both armed, one event performs both actions, and the latches receive the counts from before the reload.
- R10: With config bit 13 at 0, mask bit i selects interrupt bus line i. With it at 1, mask bits 29:0 select bus lines 61:32, mask bit 30 selects the tick strobe and mask bit 31 selects the sync strobe.
- R11: Only a 0-to-1 change of a selected source is an event. Unselected sources, sources held high and events while nothing is armed leave counts and latches unchanged.
- R12: Counter, reload and latch registers are CNT_W bits wide, and the bits above them read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_bus | input | 64 | Interrupt bus used as event sources |
| tick_strobe | input | 1 | External time-tick event source |
| sync_strobe | input | 1 | External sync event source |
| halt_req | input | 1 | Debug halt request |
| ext_clk | input | 1 | External prescaler clock |
| tmr_irq | output | NTIMERS | Per-timer underflow pulse |

## Verification
A wrong arm state shows at once in config bits 12:11, and on the next selected event it shows as latches or counts that moved or failed to move. A prescaler or counter fault shifts the count read back after a known number of unfrozen cycles by at least one, within reload+1 cycles. An error in the underflow path shows as a wrong interrupt pulse count or a wrong post-wrap value in that same sweep. A wrong source mapping or a missing edge detect shows on the first event pulse that should or should not have fired.

// File: rtl/mtl_pkg.sv
package mtl_pkg;
    // arm state encoding is {reload, capture} = config bits 12:11
    typedef enum logic [1:0] {
        ARM_NONE = 2'b00,
        ARM_CAPT = 2'b01,
        ARM_LOAD = 2'b10,
        ARM_BOTH = 2'b11
    } arm_state_t;

    localparam int BUS_W     = 32;
    localparam int ADDR_W    = 6;
    localparam int IRQBUS_W  = 64;
    localparam int SEL_W     = 32;

    localparam int CFG_EVUP  = 13;
    localparam int CFG_LOAD  = 12;
    localparam int CFG_CAPT  = 11;
    localparam int CFG_EXTCK = 10;
    localparam int CFG_NOFRZ = 9;
    localparam int CFG_SEPIR = 8;
    localparam int CFG_ENLO  = 16;

    localparam logic [ADDR_W-1:0] A_CFG  = 6'd0;
    localparam logic [ADDR_W-1:0] A_MASK = 6'd1;
    localparam logic [ADDR_W-1:0] A_PRLD = 6'd2;
    localparam logic [ADDR_W-1:0] A_PCNT = 6'd3;

    localparam logic [1:0] F_CNT = 2'd0;
    localparam logic [1:0] F_RLD = 2'd1;
    localparam logic [1:0] F_CTL = 2'd2;
    localparam logic [1:0] F_LAT = 2'd3;
endpackage

// File: rtl/mtl_prescaler.sv
module mtl_prescaler #(
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               freeze,
    input  logic               ext_sel,
    input  logic               ext_clk,
    input  logic [PRESC_W-1:0] rld,
    input  logic               cnt_wr,
    input  logic [PRESC_W-1:0] cnt_wdata,
    output logic [PRESC_W-1:0] cnt_q,
    output logic               tick
);
    logic [2:0] sync_q;
    logic       ext_rise;
    logic       pulse;

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], ext_clk};
    end

    // sync_q[1] is the second synchronizer flop, sync_q[2] its delayed copy
    assign ext_rise = sync_q[1] & ~sync_q[2];
    assign pulse    = (ext_sel ? ext_rise : 1'b1) & ~freeze;
    assign tick     = pulse && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (cnt_wr)      cnt_q <= cnt_wdata;
        else if (pulse) begin
            if (cnt_q == '0)  cnt_q <= rld;
            else              cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/mtl_event_arm.sv
module mtl_event_arm
    import mtl_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IRQBUS_W-1:0] irq_bus,
    input  logic                tick_strobe,
    input  logic                sync_strobe,
    input  logic                ev_upper,
    input  logic [SEL_W-1:0]    sel_mask,
    input  logic                arm_wr,
    input  logic [1:0]          arm_wdata,
    output arm_state_t          state_q,
    output logic                fire,
    output logic                do_load,
    output logic                do_capt
);
    logic [SEL_W-1:0] src;
    logic [SEL_W-1:0] src_prev_q;
    logic             hit;
    arm_state_t       state_d;
    logic             unused_hi;

    assign unused_hi = ^irq_bus[IRQBUS_W-1:IRQBUS_W-2];

    always_comb begin
        if (ev_upper) src = {sync_strobe, tick_strobe, irq_bus[61:32]};
        else          src = irq_bus[31:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) src_prev_q <= '0;
        else        src_prev_q <= src;
    end

    assign hit = |(src & ~src_prev_q & sel_mask);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ARM_NONE;
        else        state_q <= state_d;
    end

    // next state: event disarms, a config write overrides
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARM_NONE: state_d = ARM_NONE;
            ARM_CAPT: if (hit) state_d = ARM_NONE;
            ARM_LOAD: if (hit) state_d = ARM_NONE;
            ARM_BOTH: if (hit) state_d = ARM_NONE;
            default:  state_d = ARM_NONE;
        endcase
        if (arm_wr) state_d = arm_state_t'(arm_wdata);
    end

    // outputs
    always_comb begin
        do_load = 1'b0;
        do_capt = 1'b0;
        unique case (state_q)
            ARM_NONE: ;
            ARM_CAPT: do_capt = hit;
            ARM_LOAD: do_load = hit;
            ARM_BOTH: begin
                do_capt = hit;
                do_load = hit;
            end
            default: ;
        endcase
    end

    assign fire = do_load | do_capt;
endmodule

// File: rtl/mtl_timer_slice.sv
module mtl_timer_slice #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cnt_wr,
    input  logic             rld_wr,
    input  logic             ctl_wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             ctl_wdata,
    input  logic             en_set,
    input  logic             do_load,
    input  logic             do_capt,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] rld_q,
    output logic [CNT_W-1:0] lat_q,
    output logic             en_q,
    output logic             irq_q
);
    logic step;
    logic wrap;

    assign step = tick && en_q && !cnt_wr && !do_load;
    assign wrap = step && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (cnt_wr)   cnt_q <= wdata;
        else if (do_load)  cnt_q <= rld_q;
        else if (wrap)     cnt_q <= rld_q;
        else if (step)     cnt_q <= cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rld_q <= '0;
        else if (rld_wr) rld_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       lat_q <= '0;
        else if (do_capt) lat_q <= cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= 1'b0;
        else if (en_set) en_q <= 1'b1;
        else if (ctl_wr) en_q <= ctl_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= wrap;
    end
endmodule

// File: rtl/mtimer_latch_unit.sv
module mtimer_latch_unit
    import mtl_pkg::*;
#(
    parameter int NTIMERS = 3,
    parameter int CNT_W   = 16,
    parameter int PRESC_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic [IRQBUS_W-1:0] irq_bus,
    input  logic                tick_strobe,
    input  logic                sync_strobe,
    input  logic                halt_req,
    input  logic                ext_clk,
    output logic [NTIMERS-1:0]  tmr_irq
);
    localparam int TIDX_W = ADDR_W - 2;
    localparam int FLAT_W = NTIMERS * CNT_W;

    logic               cfg_evup_q, cfg_extck_q, cfg_nofrz_q;
    logic [SEL_W-1:0]   mask_q;
    logic [PRESC_W-1:0] prld_q;
    logic [PRESC_W-1:0] pcnt_q;
    logic               tick;
    logic               frozen;
    logic               cfg_wr;
    arm_state_t         arm_q;
    logic               ev_fire, ev_load, ev_capt;
    logic [TIDX_W-1:0]  tidx;
    logic [1:0]         tfld;

    logic [CNT_W-1:0]   cnt_a [NTIMERS];
    logic [CNT_W-1:0]   rld_a [NTIMERS];
    logic [CNT_W-1:0]   lat_a [NTIMERS];
    logic [NTIMERS-1:0] en_a;
    logic [FLAT_W-1:0]  cnt_flat, rld_flat, lat_flat;

    assign tidx   = bus_addr[ADDR_W-1:2];
    assign tfld   = bus_addr[1:0];
    assign cfg_wr = bus_wr && (bus_addr == A_CFG);
    assign frozen = halt_req && !cfg_nofrz_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_evup_q  <= 1'b0;
            cfg_extck_q <= 1'b0;
            cfg_nofrz_q <= 1'b0;
        end else if (cfg_wr) begin
            cfg_evup_q  <= bus_wdata[CFG_EVUP];
            cfg_extck_q <= bus_wdata[CFG_EXTCK];
            cfg_nofrz_q <= bus_wdata[CFG_NOFRZ];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                              mask_q <= '0;
        else if (bus_wr && bus_addr == A_MASK)   mask_q <= bus_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                              prld_q <= '0;
        else if (bus_wr && bus_addr == A_PRLD)   prld_q <= bus_wdata[PRESC_W-1:0];
    end

    mtl_prescaler #(.PRESC_W(PRESC_W)) presc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .freeze    (frozen),
        .ext_sel   (cfg_extck_q),
        .ext_clk   (ext_clk),
        .rld       (prld_q),
        .cnt_wr    (bus_wr && bus_addr == A_PCNT),
        .cnt_wdata (bus_wdata[PRESC_W-1:0]),
        .cnt_q     (pcnt_q),
        .tick      (tick)
    );

    mtl_event_arm evarm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_bus     (irq_bus),
        .tick_strobe (tick_strobe),
        .sync_strobe (sync_strobe),
        .ev_upper    (cfg_evup_q),
        .sel_mask    (mask_q),
        .arm_wr      (cfg_wr),
        .arm_wdata   ({bus_wdata[CFG_LOAD], bus_wdata[CFG_CAPT]}),
        .state_q     (arm_q),
        .fire        (ev_fire),
        .do_load     (ev_load),
        .do_capt     (ev_capt)
    );

    for (genvar k = 0; k < NTIMERS; k++) begin : g_tmr
        logic hit_k;
        assign hit_k = bus_wr && (tidx == TIDX_W'(k + 1));

        mtl_timer_slice #(.CNT_W(CNT_W)) slice_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .cnt_wr    (hit_k && tfld == F_CNT),
            .rld_wr    (hit_k && tfld == F_RLD),
            .ctl_wr    (hit_k && tfld == F_CTL),
            .wdata     (bus_wdata[CNT_W-1:0]),
            .ctl_wdata (bus_wdata[0]),
            .en_set    (cfg_wr && bus_wdata[CFG_ENLO + k]),
            .do_load   (ev_load),
            .do_capt   (ev_capt),
            .cnt_q     (cnt_a[k]),
            .rld_q     (rld_a[k]),
            .lat_q     (lat_a[k]),
            .en_q      (en_a[k]),
            .irq_q     (tmr_irq[k])
        );

        assign cnt_flat[k*CNT_W +: CNT_W] = cnt_a[k];
        assign rld_flat[k*CNT_W +: CNT_W] = rld_a[k];
        assign lat_flat[k*CNT_W +: CNT_W] = lat_a[k];
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CFG: begin
                bus_rdata[CFG_EVUP]  = cfg_evup_q;
                bus_rdata[CFG_LOAD]  = arm_q[1];
                bus_rdata[CFG_CAPT]  = arm_q[0];
                bus_rdata[CFG_EXTCK] = cfg_extck_q;
                bus_rdata[CFG_NOFRZ] = cfg_nofrz_q;
                bus_rdata[CFG_SEPIR] = 1'b1;
                bus_rdata[2:0]       = 3'(NTIMERS);
            end
            A_MASK:  bus_rdata = mask_q;
            A_PRLD:  bus_rdata = 32'(prld_q);
            A_PCNT:  bus_rdata = 32'(pcnt_q);
            default: begin
                for (int k = 0; k < NTIMERS; k++) begin
                    if (tidx == TIDX_W'(k + 1)) begin
                        unique case (tfld)
                            F_CNT: bus_rdata = 32'(cnt_a[k]);
                            F_RLD: bus_rdata = 32'(rld_a[k]);
                            F_CTL: bus_rdata = 32'(en_a[k]);
                            F_LAT: bus_rdata = 32'(lat_a[k]);
                            default: ;
                        endcase
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/mtl_checker.sv
module mtl_checker #(
    parameter int NTIMERS = 3,
    parameter int CNT_W   = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_wr,
    input logic                     tick,
    input logic                     frozen,
    input logic                     ev_fire,
    input logic [1:0]               arm_bits,
    input logic [NTIMERS-1:0]       tmr_irq,
    input logic [NTIMERS*CNT_W-1:0] cnt_flat,
    input logic [NTIMERS*CNT_W-1:0] rld_flat,
    input logic [NTIMERS*CNT_W-1:0] lat_flat
);
    AST_IRQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (|tmr_irq) |-> $past(tick)); // R4

    AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !bus_wr && !ev_fire) |=> $stable(cnt_flat)); // R5

    AST_FIRE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_fire && !bus_wr) |=> (arm_bits == 2'b00)); // R7

    AST_RELOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_fire && arm_bits[1] && !bus_wr) |=> (cnt_flat == $past(rld_flat))); // R8

    AST_LATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_fire |=> $stable(lat_flat)); // R11
endmodule

bind mtimer_latch_unit mtl_checker #(.NTIMERS(NTIMERS), .CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .tick     (tick),
    .frozen   (frozen),
    .ev_fire  (ev_fire),
    .arm_bits (arm_q),
    .tmr_irq  (tmr_irq),
    .cnt_flat (cnt_flat),
    .rld_flat (rld_flat),
    .lat_flat (lat_flat)
);

// File: tb/mtimer_latch_unit_tb.sv
`timescale 1ns/1ps
module mtimer_latch_unit_tb_top;
    localparam int NT = 3;
    localparam int CW = 8;
    localparam int PW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] irq_bus = '0;
    logic        tick_strobe = 1'b0;
    logic        sync_strobe = 1'b0;
    logic        halt_req = 1'b1;
    logic        ext_clk = 1'b0;
    logic [NT-1:0] tmr_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mtimer_latch_unit #(.NTIMERS(NT), .CNT_W(CW), .PRESC_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_bus(irq_bus),
        .tick_strobe(tick_strobe), .sync_strobe(sync_strobe),
        .halt_req(halt_req), .ext_clk(ext_clk), .tmr_irq(tmr_irq)
    );

    function automatic logic [5:0] ta(int n, int f);
        return 6'(4 * (n + 1) + f);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic rdchk(string req, logic [5:0] a, logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    // one cycle high pulse of an event source, checked at the following negedge
    task automatic pulse_bus(int bit_i);
        @(negedge clk); irq_bus[bit_i] = 1'b1;
        @(negedge clk); irq_bus[bit_i] = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rdchk("R1 cfg reset", 6'd0, 32'h0000_0103);
        rdchk("R3 cnt reset", ta(0, 0), 32'h0);
        rdchk("R2 ctl reset", ta(0, 2), 32'h0);

        // R3/R4 sweep: prescaler reload 2, timer0 count 10 reload 5
        wr(6'd2, 32'd2);
        wr(ta(0, 1), 32'd5);
        wr(ta(1, 0), 32'd50);
        wr(6'd0, 32'h0001_0000);
        for (int k = 0; k <= 40; k++) begin
            int t, ecnt, eirq, nirq;
            wr(6'd3, 32'd2);
            wr(ta(0, 0), 32'd10);
            nirq = 0;
            halt_req = 1'b0;
            for (int i = 0; i < k; i++) begin
                @(posedge clk);
                @(negedge clk);
                if (tmr_irq[0]) nirq++;
            end
            halt_req = 1'b1;
            t = k / 3;
            if (t <= 10) begin ecnt = 10 - t; eirq = 0; end
            else begin ecnt = 5 - ((t - 11) % 6); eirq = 1 + (t - 11) / 6; end
            rdchk("R3 count after ticks", ta(0, 0), 32'(ecnt));
            chk("R4 irq pulses", 32'(nirq), 32'(eirq));
        end
        rdchk("R3 disabled timer holds", ta(1, 0), 32'd50);

        // R5 frozen: halt high, no-freeze clear
        wr(6'd2, 32'd0);
        wr(6'd3, 32'd0);
        wr(ta(0, 0), 32'd100);
        repeat (10) @(negedge clk);
        rdchk("R5 frozen holds", ta(0, 0), 32'd100);
        wr(6'd0, 32'h0001_0200);
        repeat (10) @(posedge clk);
        @(negedge clk);
        rdchk("R5 no-freeze counts", ta(0, 0), 32'd90);

        // R6 external prescaler clock
        wr(6'd0, 32'h0001_0400);
        wr(ta(0, 0), 32'd100);
        wr(ta(0, 1), 32'd100);
        halt_req = 1'b0;
        repeat (20) @(negedge clk);
        rdchk("R6 no ext edges", ta(0, 0), 32'd100);
        for (int i = 0; i < 5; i++) begin
            ext_clk = 1'b1; repeat (4) @(negedge clk);
            ext_clk = 1'b0; repeat (4) @(negedge clk);
        end
        rdchk("R6 five ext edges", ta(0, 0), 32'd95);
        halt_req = 1'b1;
        ext_clk = 1'b1; repeat (4) @(negedge clk);
        ext_clk = 1'b0; repeat (4) @(negedge clk);
        rdchk("R5 frozen ext edge", ta(0, 0), 32'd95);

        // capture / reload events, counters frozen
        wr(6'd0, 32'h0);
        wr(ta(0, 0), 32'd20); wr(ta(1, 0), 32'd30); wr(ta(2, 0), 32'd40);
        wr(ta(0, 1), 32'd7);  wr(ta(1, 1), 32'd8);  wr(ta(2, 1), 32'd9);
        wr(6'd1, 32'h0000_0020);
        wr(6'd0, 32'h0000_0800);
        rdchk("R1 capture armed readback", 6'd0, 32'h0000_0903);
        pulse_bus(6);
        rdchk("R11 unselected source", ta(0, 3), 32'd0);
        rdchk("R11 still armed", 6'd0, 32'h0000_0903);
        pulse_bus(5);
        rdchk("R7 latch0", ta(0, 3), 32'd20);
        rdchk("R7 latch1", ta(1, 3), 32'd30);
        rdchk("R7 latch2", ta(2, 3), 32'd40);
        rdchk("R7 disarmed", 6'd0, 32'h0000_0103);

        // R11 level held high does not retrigger
        @(negedge clk); irq_bus[5] = 1'b1;
        wr(6'd0, 32'h0000_0800);
        wr(ta(0, 0), 32'd21);
        repeat (3) @(negedge clk);
        rdchk("R11 held level", ta(0, 3), 32'd20);
        irq_bus[5] = 1'b0;
        repeat (2) @(negedge clk);
        pulse_bus(5);
        rdchk("R11 new edge captures", ta(0, 3), 32'd21);

        // R9 both armed
        wr(6'd0, 32'h0000_1800);
        pulse_bus(5);
        rdchk("R9 count0 reloaded", ta(0, 0), 32'd7);
        rdchk("R9 count2 reloaded", ta(2, 0), 32'd9);
        rdchk("R9 latch0 pre-reload", ta(0, 3), 32'd21);
        rdchk("R9 latch1 pre-reload", ta(1, 3), 32'd30);
        rdchk("R9 disarmed", 6'd0, 32'h0000_0103);

        // R8 reload only
        wr(ta(0, 0), 32'd50); wr(ta(1, 0), 32'd51);
        wr(6'd0, 32'h0000_1000);
        rdchk("R1 reload armed readback", 6'd0, 32'h0000_1103);
        pulse_bus(5);
        rdchk("R8 count0", ta(0, 0), 32'd7);
        rdchk("R8 count1", ta(1, 0), 32'd8);
        rdchk("R8 latch untouched", ta(0, 3), 32'd21);
        rdchk("R8 disarmed", 6'd0, 32'h0000_0103);

        // R10 upper bank mapping
        wr(6'd1, 32'h0000_0001);
        wr(ta(0, 0), 32'd60);
        wr(6'd0, 32'h0000_2800);
        pulse_bus(0);
        rdchk("R10 low line ignored", ta(0, 3), 32'd21);
        pulse_bus(32);
        rdchk("R10 bus line 32", ta(0, 3), 32'd60);
        wr(6'd1, 32'h4000_0000);
        wr(ta(0, 0), 32'd61);
        wr(6'd0, 32'h0000_2800);
        @(negedge clk); tick_strobe = 1'b1;
        @(negedge clk); tick_strobe = 1'b0;
        rdchk("R10 tick strobe", ta(0, 3), 32'd61);
        wr(6'd1, 32'h8000_0000);
        wr(ta(0, 0), 32'd62);
        wr(6'd0, 32'h0000_2800);
        @(negedge clk); sync_strobe = 1'b1;
        @(negedge clk); sync_strobe = 1'b0;
        rdchk("R10 sync strobe", ta(0, 3), 32'd62);

        // R11 nothing armed
        wr(6'd0, 32'h0);
        wr(6'd1, 32'h0000_0020);
        wr(ta(0, 0), 32'd70);
        pulse_bus(5);
        rdchk("R11 unarmed latch", ta(0, 3), 32'd62);
        rdchk("R11 unarmed count", ta(0, 0), 32'd70);

        // R12 width
        wr(ta(0, 0), 32'hFFFF_FFFF);
        rdchk("R12 count upper zero", ta(0, 0), 32'h0000_00FF);
        wr(ta(1, 1), 32'hFFFF_FF5A);
        rdchk("R12 reload upper zero", ta(1, 1), 32'h0000_005A);

        // R2 enable set bits
        wr(ta(2, 2), 32'h0);
        rdchk("R2 ctl cleared", ta(2, 2), 32'h0);
        wr(6'd0, 32'h0004_0000);
        rdchk("R2 cfg sets enable", ta(2, 2), 32'h1);
        rdchk("R2 other timer untouched", ta(1, 2), 32'h0);
        wr(6'd0, 32'h0000_0000);
        rdchk("R2 zero no effect", ta(2, 2), 32'h1);

        // R1 reserved bits
        wr(6'd0, 32'hFFFF_FFFF);
        rdchk("R1 cfg all ones", 6'd0, 32'h0000_3F03);
        wr(6'd0, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule